// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output slice of a small programmable logic array. A bus of array lines, carrying each signal in true and complement form, feeds a plane of product terms. Each term is a programmable AND over any subset of those lines. The terms are ORed into a single sum, which passes through a polarity stage and then goes either to a clocked register or straight to the output driver. The cell also picks the source of its output enable and the signal it sends back into the array as feedback.

All configuration arrives as static inputs. These are the connection mask of the AND plane, one disable bit per term, two global mode bits shared by every slice, and two per-cell bits. Eight of these slices sharing one array bus, one clock and one enable pin make up a complete device.

The three mode bits select one of five personalities: registered output, combinational I/O inside the registered family, plain combinational output, dedicated input, and combinational I/O for the all-combinational family. The three remaining codes are flagged as errors.

Top module: `sop_macrocell`

## Requirements
- R1: A product term is the AND of every array line whose connection bit is 1; term t uses bits t*NUM_LINES+l of `and_conn` for line l. A term with no connected lines evaluates to 1.
- R2: When bit t of `term_off` is 1, term t adds 0 to the OR sum, and when it is the output-enable term, it disables the output.
- R3: With `cell_pol`=1 the polarity stage passes the OR sum unchanged; with `cell_pol`=0 it inverts it. Outside registered mode, `pin_out` is the inverse of the polarity-stage value because the driver is active low.
- R4: Mode code {glb_mode[1], glb_mode[0], cell_sel} = 010 is registered. The register loads the polarity-stage value on each rising clock edge. `pin_out` is the inverse of the register, `pin_oe` is the inverse of `oe_n_pin`, and `fb_out` is the register.
- R5: While `rst_n` is low, the register is cleared to 0, so in registered mode `pin_out` reads 1 and `fb_out` reads 0.
- R6: Codes 011 and 111 use term 0 as the output enable (`pin_oe` = term 0). The OR sum covers terms 1 to NUM_TERMS-1 only, and `fb_out` is `pin_in`.
- R7: Code 100 drives the output permanently (`pin_oe`=1) and feeds back the adjacent cell's pin (`fb_out` = `adj_pin_in`).
- R8: Code 101 is a dedicated input: `pin_oe`=0 and `fb_out` = `pin_in`.
- R9: Codes 000, 001 and 110 give `pin_oe`=0, `fb_out` = `pin_in` and `cfg_err`=1. Every valid code gives `cfg_err`=0.
- R10: Outside registered mode the register holds its value. Re-entering code 010 shows that held value on `pin_out` before any further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared array clock |
| rst_n | input | 1 | Active-low power-up clear of the register |
| arr_lines | input | NUM_LINES | True/complement array input lines |
| and_conn | input | NUM_TERMS*NUM_LINES | Connection mask of the AND plane |
| term_off | input | NUM_TERMS | Per-term disable bits |
| glb_mode | input | 2 | Global mode bits shared by all slices |
| cell_sel | input | 1 | Per-cell personality bit |
| cell_pol | input | 1 | Per-cell polarity bit |
| oe_n_pin | input | 1 | Shared active-low external output enable |
| pin_in | input | 1 | Level present on this cell's own pin |
| adj_pin_in | input | 1 | Level present on the adjacent cell's pin |
| pin_out | output | 1 | Value presented to the pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback line returned to the array |
| cfg_err | output | 1 | Unused mode code selected |

## Verification
The bench uses the default sizes: 32 array lines and 8 terms. This gives a 256-bit connection mask, which is wide enough for sparse random masks to make individual terms true at a useful rate. With 8 terms, removing term 0 from the OR sum can be told apart from the full sum. The full 3-bit mode space is reachable, including the three error codes. Random cycles switch codes freely, so the register's hold behaviour outside registered mode is exercised against a bench-side register model.

// File: rtl/sop_pkg.sv
package sop_pkg;

   typedef enum logic [1:0] {
      OE_EXT  = 2'd0,
      OE_TERM = 2'd1,
      OE_ON   = 2'd2,
      OE_OFF  = 2'd3
   } oe_src_e;

   typedef enum logic [1:0] {
      FB_OWN = 2'd0,
      FB_ADJ = 2'd1,
      FB_REG = 2'd2
   } fb_src_e;

   typedef struct packed {
      logic    use_reg;
      logic    term0_oe;
      oe_src_e oe_src;
      fb_src_e fb_src;
      logic    bad;
   } cell_cfg_t;

endpackage

// File: rtl/sop_mode_decode.sv
module sop_mode_decode
   import sop_pkg::*;
(
   input  logic [1:0] glb_mode,
   input  logic       cell_sel,
   output cell_cfg_t  cfg
);

   always_comb begin
      cfg = '{use_reg: 1'b0, term0_oe: 1'b0, oe_src: OE_OFF, fb_src: FB_OWN, bad: 1'b0};
      case ({glb_mode, cell_sel})
         3'b010: begin
            cfg.use_reg = 1'b1;
            cfg.oe_src  = OE_EXT;
            cfg.fb_src  = FB_REG;
         end
         3'b011, 3'b111: begin
            cfg.term0_oe = 1'b1;
            cfg.oe_src   = OE_TERM;
         end
         3'b100: begin
            cfg.oe_src = OE_ON;
            cfg.fb_src = FB_ADJ;
         end
         3'b101: cfg.oe_src = OE_OFF;
         default: cfg.bad = 1'b1;
      endcase
   end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
   parameter int NUM_LINES = 32,
   parameter int NUM_TERMS = 8,
   localparam int CONN_W = NUM_LINES * NUM_TERMS
) (
   input  logic [NUM_LINES-1:0] lines,
   input  logic [CONN_W-1:0]    conn,
   input  logic [NUM_TERMS-1:0] off,
   output logic [NUM_TERMS-1:0] terms
);

   for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
      logic [NUM_LINES-1:0] row;
      assign row      = conn[t*NUM_LINES +: NUM_LINES];
      assign terms[t] = ~off[t] & (&(lines | ~row));
   end

endmodule

// File: rtl/sop_or_sum.sv
module sop_or_sum #(
   parameter int NUM_TERMS = 8
) (
   input  logic [NUM_TERMS-1:0] terms,
   input  logic                 term0_oe,
   input  logic                 pol,
   output logic                 sum_adj,
   output logic                 oe_term
);

   localparam logic [NUM_TERMS-1:0] ALL_ON = '1;
   localparam logic [NUM_TERMS-1:0] SKIP_0 = {ALL_ON[NUM_TERMS-1:1], 1'b0};

   logic [NUM_TERMS-1:0] mask;
   logic                 raw_sum;

   assign mask    = term0_oe ? SKIP_0 : ALL_ON;
   assign raw_sum = |(terms & mask);
   assign sum_adj = pol ? raw_sum : ~raw_sum;
   assign oe_term = terms[0];

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
   import sop_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int NUM_TERMS = 8,
   localparam int CONN_W = NUM_LINES * NUM_TERMS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] arr_lines,
   input  logic [CONN_W-1:0]    and_conn,
   input  logic [NUM_TERMS-1:0] term_off,
   input  logic [1:0]           glb_mode,
   input  logic                 cell_sel,
   input  logic                 cell_pol,
   input  logic                 oe_n_pin,
   input  logic                 pin_in,
   input  logic                 adj_pin_in,
   output logic                 pin_out,
   output logic                 pin_oe,
   output logic                 fb_out,
   output logic                 cfg_err
);

   if (NUM_TERMS < 2) begin : g_bad_terms
      $error("sop_macrocell: NUM_TERMS must be at least 2");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("sop_macrocell: NUM_LINES must be at least 1");
   end

   cell_cfg_t            cfg;
   logic [NUM_TERMS-1:0] terms;
   logic                 sum_adj;
   logic                 oe_term;
   logic                 q;

   sop_mode_decode u_dec (
      .glb_mode (glb_mode),
      .cell_sel (cell_sel),
      .cfg      (cfg)
   );

   sop_and_plane #(.NUM_LINES(NUM_LINES), .NUM_TERMS(NUM_TERMS)) u_and (
      .lines (arr_lines),
      .conn  (and_conn),
      .off   (term_off),
      .terms (terms)
   );

   sop_or_sum #(.NUM_TERMS(NUM_TERMS)) u_or (
      .terms    (terms),
      .term0_oe (cfg.term0_oe),
      .pol      (cell_pol),
      .sum_adj  (sum_adj),
      .oe_term  (oe_term)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q <= 1'b0;
      else if (cfg.use_reg) q <= sum_adj;
   end

   assign pin_out = cfg.use_reg ? ~q : ~sum_adj;
   assign cfg_err = cfg.bad;

   always_comb begin
      case (cfg.oe_src)
         OE_EXT:  pin_oe = ~oe_n_pin;
         OE_TERM: pin_oe = oe_term;
         OE_ON:   pin_oe = 1'b1;
         default: pin_oe = 1'b0;
      endcase
   end

   always_comb begin
      case (cfg.fb_src)
         FB_REG:  fb_out = q;
         FB_ADJ:  fb_out = adj_pin_in;
         default: fb_out = pin_in;
      endcase
   end

endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] glb_mode,
   input logic       cell_sel,
   input logic       oe_n_pin,
   input logic       pin_out,
   input logic       pin_oe,
   input logic       fb_out,
   input logic       cfg_err,
   input logic       sum_adj
);

   logic [2:0] code;
   assign code = {glb_mode, cell_sel};

   p_ext_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 3'b010) |-> (pin_oe == !oe_n_pin));

   p_reg_fb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 3'b010) |-> (fb_out == !pin_out));

   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((code == 3'b010) && $past(code == 3'b010) && $past(rst_n)) |-> (pin_out == !$past(sum_adj)));

   p_drive_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 3'b100) |-> pin_oe);

   p_din_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 3'b101) |-> !pin_oe);

   p_err_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !pin_oe);

endmodule

bind sop_macrocell sop_macrocell_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .glb_mode (glb_mode),
   .cell_sel (cell_sel),
   .oe_n_pin (oe_n_pin),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .fb_out   (fb_out),
   .cfg_err  (cfg_err),
   .sum_adj  (sum_adj)
);

// File: tb/sop_macrocell_bench.sv
module sop_macrocell_bench;

   localparam int NL = 32;
   localparam int NT = 8;
   localparam int CW = NL * NT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] lines = '0;
   logic [CW-1:0] conn = '0;
   logic [NT-1:0] off = '0;
   logic [1:0]    gm = 2'b01;
   logic          cs = 1'b0;
   logic          pol = 1'b1;
   logic          oen = 1'b0;
   logic          pin_in = 1'b0;
   logic          adj_in = 1'b0;
   logic          pin_out, pin_oe, fb_out, cfg_err;

   int   checks = 0;
   int   fails = 0;
   logic q_m = 1'b0;

   always #4 clk = ~clk;

   sop_macrocell #(.NUM_LINES(NL), .NUM_TERMS(NT)) u_sop_macrocell (
      .clk        (clk),
      .rst_n      (rst_n),
      .arr_lines  (lines),
      .and_conn   (conn),
      .term_off   (off),
      .glb_mode   (gm),
      .cell_sel   (cs),
      .cell_pol   (pol),
      .oe_n_pin   (oen),
      .pin_in     (pin_in),
      .adj_pin_in (adj_in),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe),
      .fb_out     (fb_out),
      .cfg_err    (cfg_err)
   );

   function automatic logic term_val(int t);
      logic v = !off[t];
      for (int l = 0; l < NL; l++)
         if (conn[t*NL + l] && !lines[l]) v = 1'b0;
      return v;
   endfunction

   function automatic logic exp_d();
      logic [2:0] code = {gm, cs};
      logic s = 1'b0;
      for (int t = 0; t < NT; t++) begin
         if (!(t == 0 && (code == 3'b011 || code == 3'b111)))
            s = s | term_val(t);
      end
      return pol ? s : !s;
   endfunction

   function automatic logic exp_oe();
      case ({gm, cs})
         3'b010:         return !oen;
         3'b011, 3'b111: return term_val(0);
         3'b100:         return 1'b1;
         default:        return 1'b0;
      endcase
   endfunction

   function automatic logic exp_fb();
      case ({gm, cs})
         3'b010:  return q_m;
         3'b100:  return adj_in;
         default: return pin_in;
      endcase
   endfunction

   function automatic logic exp_err();
      logic [2:0] c = {gm, cs};
      return (c == 3'b000 || c == 3'b001 || c == 3'b110);
   endfunction

   function automatic logic exp_pin();
      return ({gm, cs} == 3'b010) ? !q_m : !exp_d();
   endfunction

   function automatic string code_tag();
      case ({gm, cs})
         3'b010:         return "R4";
         3'b011, 3'b111: return "R6";
         3'b100:         return "R7";
         3'b101:         return "R8";
         default:        return "R9";
      endcase
   endfunction

   task automatic chk1(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s code=%b actual=%b expected=%b", tag, what, {gm, cs}, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk1(tag, "pin_out", pin_out, exp_pin());
      chk1(tag, "pin_oe",  pin_oe,  exp_oe());
      chk1(tag, "fb_out",  fb_out,  exp_fb());
      chk1(tag, "cfg_err", cfg_err, exp_err());
   endtask

   task automatic tick();
      @(posedge clk);
      if (rst_n && {gm, cs} == 3'b010) q_m = exp_d();
   endtask

   // entered and left at a falling edge; inputs are driven there
   task automatic step(string tag);
      #1 check_all(tag);
      tick();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unsigned seed = $urandom(32'd2718);
      // R5: reset state in registered mode
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1 check_all("R5");
      rst_n = 1'b1;
      tick();
      @(negedge clk);
      step("R4");

      // R1: unconnected term is 1; a connected low line kills it
      {gm, cs} = 3'b100; pol = 1'b1; conn = '0; off = 8'hFE;
      step("R1");
      conn[5] = 1'b1; lines[5] = 1'b0;
      step("R1");
      lines[5] = 1'b1;
      step("R1");
      // R2: all terms disabled
      conn = '0; off = 8'hFF;
      step("R2");
      // R3: inverted polarity
      pol = 1'b0;
      step("R3");
      pol = 1'b1;
      // R6: term 0 as enable, excluded from sum
      {gm, cs} = 3'b011; off = 8'hFE;
      step("R6");
      off = 8'h01;
      step("R6");
      {gm, cs} = 3'b111; off = 8'hFE; pin_in = 1'b1;
      step("R6");
      // R9: unused codes
      {gm, cs} = 3'b000; step("R9");
      {gm, cs} = 3'b001; step("R9");
      {gm, cs} = 3'b110; step("R9");
      // R7 and R8: feedback source
      pin_in = 1'b0; adj_in = 1'b1;
      {gm, cs} = 3'b100; step("R7");
      {gm, cs} = 3'b101; step("R8");
      // R10: register holds outside registered mode
      {gm, cs} = 3'b010; off = 8'h00; oen = 1'b0;
      step("R10");
      {gm, cs} = 3'b100; off = 8'hFF;
      repeat (3) step("R10");
      {gm, cs} = 3'b010;
      step("R10");

      // random mix over all codes
      for (int i = 0; i < 800; i++) begin
         lines = $urandom;
         for (int w = 0; w < CW; w++) conn[w] = ($urandom % 12 == 0);
         off = ($urandom % 4 == 0) ? NT'($urandom) : '0;
         {gm, cs} = 3'($urandom);
         pol    = 1'($urandom);
         oen    = 1'($urandom);
         pin_in = 1'($urandom);
         adj_in = 1'($urandom);
         step(code_tag());
      end
      if (seed == 0) checks = checks + 0;
      finish_run();
   end

endmodule